// File: doc/BRIEF.md
# Instruction Group Dispatch Throttle

This block sits between instruction fetch and issue. Fetched 64-bit words arrive over a valid/ready handshake in aligned groups of eight. The first word of every group is a scheduling control word. The throttle absorbs it and keeps its interval fields. It then passes the seven instruction words that follow downstream over a second valid/ready handshake. Each issue is held back until the interval programmed for the preceding instruction has elapsed.

The block does not decode instructions. It tracks the word position within the group, checks the fixed marker bits of each control word, and runs a single countdown timer that gates issue. A synchronous flush restarts the group count, so that the next accepted word is taken as a control word. A malformed control word raises an error flag. The group it heads is then issued without any throttling.

Top module: `grp_issue_throttle`

## Requirements
- R1: Word 0 of every 8-word group (counted in accepted words since reset or flush) is a control word. It is accepted with in_ready high whatever out_ready is, and it never appears on the issue interface.
- R2: Control word layout: bits [3:0] equal 4'b0111 and bits [63:60] equal 4'b0010. Interval field k (k = 0..6) occupies bits [11+8k:4+8k], with its least significant bit at the lowest bit position.
- R3: With interval field k holding N, instruction k+1 of the group issues no earlier than N clock edges after instruction k issued, for k = 0..5. Values 0 and 1 both allow issue on consecutive edges.
- R4: Instruction 0 of a group may issue on the edge right after its control word is accepted. Field 6 has no effect, so instruction 0 of the next group follows instruction 6 after only the one edge that the control word takes.
- R5: Instruction words pass to out_data unchanged. On an instruction slot, out_valid is in_valid gated by the interval timer, and in_ready equals out_ready gated by the same timer.
- R6: A control word whose marker bits differ from R2 sets ctl_err from the next edge. ctl_err stays set until the next control word is accepted or a flush occurs. Every instruction of that group may then issue back to back.
- R7: While flush is high, in_ready and out_valid are low. The next accepted word is treated as a control word, and any pending interval is discarded.
- R8: After reset the block expects a control word: in_ready is high, out_valid is low and ctl_err is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous group restart |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Fetch word accepted when high with in_valid |
| in_data | input | 64 | Fetch word |
| out_valid | output | 1 | Instruction available to issue |
| out_ready | input | 1 | Issue stage can take the instruction |
| out_data | output | 64 | Instruction word being issued |
| ctl_err | output | 1 | Current group's control word was malformed |

## Verification
On every cycle, the assertions check the following:
- an issue with a programmed interval of two or more is followed by a cycle without out_valid;
- an accepted control word is never offered downstream;
- a malformed control word raises ctl_err;
- the timer counts down one step per cycle;
- a flush leaves the block ready for a control word.

The exact spacing between issues, equal to the programmed interval and not merely at least two, can only be shown by the bench's scenarios. The same holds for the bit order of the fields, the freedom of the group boundary from field 6, and data integrity under backpressure. The scenarios also check that a word arriving after a mid-group flush is consumed as a control word and not issued.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
   localparam int unsigned MARK_W   = 4;
   localparam logic [3:0]  HEAD_TAG = 4'b0111;
   localparam logic [3:0]  TAIL_TAG = 4'b0010;
endpackage

// File: rtl/gdt_ctl_decode.sv
module gdt_ctl_decode
   import gdt_pkg::*;
#(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned N_SLOT = 7,
   parameter int unsigned IVL_W  = 8
) (
   input  logic [WORD_W-1:0]             word,
   output logic                          well_formed,
   output logic [N_SLOT-1:0][IVL_W-1:0]  ivl
);
   localparam int unsigned PACK_W = 2*MARK_W + N_SLOT*IVL_W;

   if (PACK_W != WORD_W) begin : g_width_bad
      $error("control word width does not match marker and field widths");
   end

   for (genvar k = 0; k < N_SLOT; k++) begin : g_fld
      assign ivl[k] = word[MARK_W + k*IVL_W +: IVL_W];
   end

   assign well_formed = (word[MARK_W-1:0] == HEAD_TAG) &&
                        (word[WORD_W-1 -: MARK_W] == TAIL_TAG);
endmodule

// File: rtl/gdt_slot_ctr.sv
module gdt_slot_ctr #(
   parameter int unsigned GROUP  = 8,
   localparam int unsigned SLOT_W = $clog2(GROUP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   output logic [SLOT_W-1:0] slot
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(GROUP-1);

   if (GROUP < 2 || (1 << SLOT_W) != GROUP) begin : g_group_bad
      $error("group size must be a power of two of at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         slot <= '0;
      else if (adv)
         slot <= (slot == LAST) ? '0 : slot + 1'b1;
   end

   // R1
   slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && adv && slot == LAST) |=> (slot == '0));
endmodule

// File: rtl/gdt_gap_timer.sv
module gdt_gap_timer #(
   parameter int unsigned IVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [IVL_W-1:0] ivl,
   output logic             open
);
   logic [IVL_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (load)
         cnt <= (ivl == '0) ? '0 : ivl - 1'b1;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign open = (cnt == '0);

   // R3
   gap_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && !clr && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/grp_issue_throttle.sv
module grp_issue_throttle
   import gdt_pkg::*;
#(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned N_SLOT = 7,
   parameter int unsigned IVL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              ctl_err
);
   localparam int unsigned GROUP  = N_SLOT + 1;
   localparam int unsigned SLOT_W = $clog2(GROUP);

   logic [SLOT_W-1:0]            slot;
   logic                         at_ctl, gap_open, acc, ctl_acc, fire;
   logic                         well_formed;
   logic [N_SLOT-1:0][IVL_W-1:0] dec_ivl;
   logic [N_SLOT-1:0][IVL_W-1:0] ivl_q;
   logic [IVL_W-1:0]             sel_ivl;
   logic                         err_q;

   gdt_ctl_decode #(.WORD_W(WORD_W), .N_SLOT(N_SLOT), .IVL_W(IVL_W)) u_dec (
      .word(in_data), .well_formed(well_formed), .ivl(dec_ivl));

   gdt_slot_ctr #(.GROUP(GROUP)) u_slot (
      .clk(clk), .rst_n(rst_n), .restart(flush), .adv(acc), .slot(slot));

   gdt_gap_timer #(.IVL_W(IVL_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .clr(flush || ctl_acc), .load(fire),
      .ivl(sel_ivl), .open(gap_open));

   assign at_ctl    = (slot == '0);
   assign out_valid = !flush && in_valid && !at_ctl && gap_open;
   assign in_ready  = !flush && (at_ctl || (out_ready && gap_open));
   assign out_data  = in_data;
   assign acc       = in_valid && in_ready;
   assign ctl_acc   = acc && at_ctl;
   assign fire      = acc && !at_ctl;
   assign ctl_err   = err_q;

   // interval after the instruction in this slot; the last slot hands over to the next group
   always_comb begin
      sel_ivl = '0;
      for (int k = 0; k < N_SLOT; k++)
         if (slot == SLOT_W'(k + 1))
            sel_ivl = (k < N_SLOT - 1) ? ivl_q[k] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ivl_q <= '0;
         err_q <= 1'b0;
      end else if (flush) begin
         err_q <= 1'b0;
      end else if (ctl_acc) begin
         ivl_q <= well_formed ? dec_ivl : '0;
         err_q <= !well_formed;
      end
   end

   // R1
   no_ctl_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_acc |-> !out_valid);
   // R3
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel_ivl >= IVL_W'(2)) |=> !out_valid);
   // R4
   grp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_acc |=> (flush || gap_open));
   // R6
   bad_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_acc && !well_formed && !flush) |=> ctl_err);
   // R7
   flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (flush || in_ready));
endmodule

// File: tb/grp_issue_throttle_bench.sv
`timescale 1ns/1ps
module grp_issue_throttle_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_data;
   logic        ctl_err;

   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   bit          seen;
   logic [63:0] seen_data;
   int          seen_cyc;
   int          last_cyc;
   int          first_cyc;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   grp_issue_throttle u_grp_issue_throttle (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .ctl_err(ctl_err));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_ctl(input logic [7:0] o [7]);
      return {4'b0010, o[6], o[5], o[4], o[3], o[2], o[1], o[0], 4'b0111};
   endfunction

   function automatic int exp_gap(input logic [7:0] n);
      return (n <= 8'd1) ? 1 : int'(n);
   endfunction

   task automatic send(input logic [63:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      seen      = out_valid;
      seen_data = out_data;
      seen_cyc  = cyc;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   // one full group: control word then seven instructions
   task automatic run_group(input logic [63:0] ctl, input logic [7:0] o [7],
                            input bit bad, input logic [63:0] base);
      int prev;
      send(ctl);
      chk(!seen, "R1 control word not issued", 64'(seen), 64'd0);
      chk(ctl_err == bad, "R6 ctl_err after control", 64'(ctl_err), 64'(bad));
      prev = seen_cyc;
      for (int k = 0; k < 7; k++) begin
         logic [63:0] w;
         w = base + 64'(k);
         send(w);
         chk(seen && seen_data == w, "R5 issued data", seen_data, w);
         if (k == 0) begin
            chk(seen_cyc - prev == 1, "R4 first instruction gap",
                64'(seen_cyc - prev), 64'd1);
            first_cyc = seen_cyc;
         end else if (bad) begin
            chk(seen_cyc - prev == 1, "R6 unthrottled gap",
                64'(seen_cyc - prev), 64'd1);
         end else begin
            chk(seen_cyc - prev == exp_gap(o[k-1]), "R3 interval gap",
                64'(seen_cyc - prev), 64'(exp_gap(o[k-1])));
         end
         prev = seen_cyc;
      end
      last_cyc = prev;
   endtask

   task automatic t_reset();
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R8 in_ready after reset", 64'(in_ready), 64'd1);
      chk(out_valid == 1'b0, "R8 out_valid after reset", 64'(out_valid), 64'd0);
      chk(ctl_err == 1'b0, "R8 ctl_err after reset", 64'(ctl_err), 64'd0);
   endtask

   task automatic t_basic();
      logic [7:0] o1 [7] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd0, 8'd9};
      // R2 field order and bit order: 0x06 and 0x0C would read as 0x60 and 0x30 if reversed
      logic [7:0] o2 [7] = '{8'h06, 8'h0C, 8'd1, 8'd4, 8'd2, 8'd3, 8'hFF};
      int c6;
      run_group(mk_ctl(o1), o1, 1'b0, 64'hA5A5_0000_0000_0100);
      c6 = last_cyc;
      run_group(mk_ctl(o2), o2, 1'b0, 64'h5A5A_0000_0000_0200);
      chk(first_cyc - c6 == 2, "R4 field 6 has no effect",
          64'(first_cyc - c6), 64'd2);
   endtask

   task automatic t_bad();
      logic [7:0] o [7] = '{8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7};
      run_group(mk_ctl(o) ^ 64'h1, o, 1'b1, 64'h1111_0000_0000_0000);
      run_group(mk_ctl(o) ^ (64'h1 << 61), o, 1'b1, 64'h2222_0000_0000_0000);
      run_group(mk_ctl(o), o, 1'b0, 64'h3333_0000_0000_0000);
   endtask

   task automatic t_max();
      logic [7:0] o [7] = '{8'hFF, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
      run_group(mk_ctl(o), o, 1'b0, 64'h4444_0000_0000_0000);
   endtask

   task automatic t_flush();
      logic [7:0] oa [7] = '{8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4};
      logic [7:0] ob [7] = '{8'd3, 8'd1, 8'd2, 8'd1, 8'd1, 8'd1, 8'd1};
      send(mk_ctl(oa));
      send(64'h6666_0000_0000_0000);
      @(negedge clk);
      flush    = 1'b1;
      in_valid = 1'b1;
      in_data  = 64'h6666_0000_0000_0001;
      #1;
      chk(in_ready == 1'b0, "R7 in_ready during flush", 64'(in_ready), 64'd0);
      chk(out_valid == 1'b0, "R7 out_valid during flush", 64'(out_valid), 64'd0);
      @(posedge clk);
      #1;
      flush    = 1'b0;
      in_valid = 1'b0;
      run_group(mk_ctl(ob), ob, 1'b0, 64'h7777_0000_0000_0000);
   endtask

   task automatic t_backpressure();
      logic [7:0] o [7] = '{8'd3, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1};
      int c0;
      out_ready = 1'b0;
      send(mk_ctl(o));
      chk(!seen, "R1 control accepted under backpressure", 64'(seen), 64'd0);
      out_ready = 1'b1;
      send(64'h8888_0000_0000_0000);
      c0 = seen_cyc;
      @(negedge clk);
      out_ready = 1'b0;
      in_valid  = 1'b1;
      in_data   = 64'h8888_0000_0000_0001;
      for (int i = 0; i < 6; i++) begin
         #1;
         chk(in_ready == 1'b0, "R5 in_ready follows out_ready", 64'(in_ready), 64'd0);
         @(negedge clk);
      end
      #1;
      chk(out_valid && out_data == 64'h8888_0000_0000_0001, "R5 held offer",
          out_data, 64'h8888_0000_0000_0001);
      out_ready = 1'b1;
      #1;
      chk(in_ready == 1'b1, "R5 release", 64'(in_ready), 64'd1);
      chk(cyc - c0 >= 3, "R3 gap under backpressure", 64'(cyc - c0), 64'd3);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      for (int k = 2; k < 7; k++) begin
         send(64'h8888_0000_0000_0000 + 64'(k));
         chk(seen, "R5 remaining issue", 64'(seen), 64'd1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_bad();
      t_max();
      t_flush();
      t_backpressure();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule